// File: doc/BRIEF.md
# Shader Program Flow-Control Sequencer

This block holds the instruction pointer of a small shader program processor and decides which slot is fetched next. Each enabled cycle it looks at the instruction currently presented for the pointer: three of its 32-bit words, a flag that says an operand carries an inline constant, and a pass/fail result from an external condition unit. Ordinary instructions move the pointer forward by their length. Flow-control instructions can arm one pending if/else skip, start one counted loop, break out of that loop, or end the program.

The pending skip and the loop end are not acted on when they are armed. Instead, every newly computed pointer is compared against them, and a match redirects it. The pending skip is tested before the loop end. A program ends when an instruction with its last-marker bit is stepped, or when a return is stepped. The pointer then freezes and `done` stays high until reset.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, `pc` is 0, `done` is 0, and no skip or loop is pending, so no address redirects the pointer.
- R2: A stepped ordinary instruction (word 2 bit 31 clear) advances `pc` by 1, or by 2 when `ins_has_const` is high, unless a redirect applies.
- R3: When `step_en` is low, or once `done` is high, `pc` and all pending state hold.
- R4: Stepping an instruction whose word 0 bit 0 is set raises `done` and leaves `pc` unchanged. `done` stays high until reset.
- R5: A flow instruction (word 2 bit 31 set) with opcode field word 0 bits 29:24 equal to 5 (return) raises `done`.
- R6: An if (opcode 2) with `cond_pass` high, and with word 2 bits 30:2 less than word 3 bits 30:2, advances by 1. It arms a skip from address word2>>2 to address word3>>2. When a computed pointer equals the skip source, the pointer becomes the skip target and the skip is disarmed.
- R7: An if with `cond_pass` high whose word 2 address is not below its word 3 address arms nothing and advances by 1.
- R8: An if with `cond_pass` low moves the pointer to word2>>2.
- R9: A loop (opcode 3) or repeat (opcode 4) with `cond_pass` high does three things: it loads a trip counter, sets the loop start to `pc`+1, and sets the loop end to word3>>2. When a computed pointer equals the loop end and the counter is nonzero, the counter decrements and the pointer goes to the loop start. When the counter is zero, the loop is disarmed and the pointer stays at the loop end.
- R10: The trip count is (word 2 bits 9:2 minus bits 17:10) divided by bits 26:19, truncated. It is 0 when the difference is negative or the divisor is 0.
- R11: A loop or repeat with `cond_pass` low moves the pointer to word3>>2.
- R12: A break (opcode 0) while a loop is armed moves the pointer to the loop end and zeroes the counter, which then disarms the loop. With no loop armed it advances by 1.
- R13: Flow instructions are always one slot long, whatever `ins_has_const` says. Opcode 1 and other unlisted flow opcodes just advance by 1.
- R14: The redirect comparison applies to every computed pointer, including one produced by a flow jump. When the skip source and the loop end are equal, the skip wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Step the presented instruction this cycle |
| ins_w0 | input | 32 | Word 0: bit 0 last marker, bits 29:24 opcode |
| ins_w2 | input | 32 | Word 2: bit 31 flow flag, address or loop fields |
| ins_w3 | input | 32 | Word 3: target address in bits 31:2 |
| ins_has_const | input | 1 | An operand is an inline constant (two-slot instruction) |
| cond_pass | input | 1 | Condition result for the presented instruction |
| pc | output | PC_W | Instruction pointer of the presented slot |
| done | output | 1 | Program finished |

## Verification
Two functions can act in the same step: the pending skip compare and the loop-end compare. They can also act on a pointer that a flow jump has just produced. The bench arms a loop whose end equals the source of a later skip, and checks that stepping onto that address takes the skip target while the loop stays armed. It then jumps back onto the loop end with a failing if, and checks that the counter is consumed and the pointer returns to the loop start.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int WORD_W    = 32;
  localparam int FIELD_W   = 8;
  localparam int OP_LSB    = 24;
  localparam int OP_W      = 6;
  localparam int FLOW_BIT  = 31;
  localparam int LAST_BIT  = 0;
  localparam int START_LSB = 2;
  localparam int STOP_LSB  = 10;
  localparam int INCR_LSB  = 19;

  typedef enum logic [OP_W-1:0] {
    FC_BRK  = 6'd0,
    FC_CAL  = 6'd1,
    FC_IF   = 6'd2,
    FC_LOOP = 6'd3,
    FC_REP  = 6'd4,
    FC_RET  = 6'd5
  } fc_op_e;
endpackage

// File: rtl/sfs_rst_sync.sv
module sfs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/sfs_trip_calc.sv
module sfs_trip_calc
  import sfs_pkg::*;
(
  input  logic [FIELD_W-1:0] first,
  input  logic [FIELD_W-1:0] last,
  input  logic [FIELD_W-1:0] stride,
  output logic [FIELD_W-1:0] trips
);
  logic [FIELD_W:0] span;

  always_comb begin
    span = {1'b0, first} - {1'b0, last};
    if (span[FIELD_W] || (stride == '0)) trips = '0;
    else                                 trips = span[FIELD_W-1:0] / stride;
  end

  always_comb begin
    if (!span[FIELD_W] && (stride != '0))
      AST_TRIP_BOUND: assert (({{FIELD_W{1'b0}}, trips} * {{FIELD_W{1'b0}}, stride})
                              <= {{FIELD_W{1'b0}}, span[FIELD_W-1:0]}); // R10
  end
endmodule

// File: rtl/sfs_redirect.sv
module sfs_redirect
  import sfs_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic [PC_W-1:0]    cand,
  input  logic [PC_W-1:0]    tst_i,
  input  logic [PC_W-1:0]    jmp_i,
  input  logic [PC_W-1:0]    ls_i,
  input  logic [PC_W-1:0]    le_i,
  input  logic [FIELD_W-1:0] cnt_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    tst_o,
  output logic [PC_W-1:0]    jmp_o,
  output logic [PC_W-1:0]    ls_o,
  output logic [PC_W-1:0]    le_o,
  output logic [FIELD_W-1:0] cnt_o,
  output logic               hit_o
);
  localparam logic [PC_W-1:0] INV = '1;

  always_comb begin
    pc_o  = cand;
    tst_o = tst_i;
    jmp_o = jmp_i;
    ls_o  = ls_i;
    le_o  = le_i;
    cnt_o = cnt_i;
    hit_o = 1'b0;
    if ((tst_i != INV) && (cand == tst_i)) begin
      pc_o  = jmp_i;
      tst_o = INV;
      jmp_o = INV;
      hit_o = 1'b1;
    end else if ((le_i != INV) && (cand == le_i)) begin
      hit_o = 1'b1;
      if (cnt_i != '0) begin
        cnt_o = cnt_i - 1'b1;
        pc_o  = ls_i;
      end else begin
        ls_o = INV;
        le_o = INV;
      end
    end
  end
endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
  import sfs_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [31:0]       ins_w0,
  input  logic [31:0]       ins_w2,
  input  logic [31:0]       ins_w3,
  input  logic              ins_has_const,
  input  logic              cond_pass,
  output logic [PC_W-1:0]   pc,
  output logic              done
);
  localparam logic [PC_W-1:0] INV = '1;
  localparam int ADR_HI = PC_W + 1;

  logic rst_n_s;

  logic [PC_W-1:0]    pc_q, tst_q, jmp_q, ls_q, le_q;
  logic [FIELD_W-1:0] cnt_q;
  logic               done_q;

  logic [PC_W-1:0]    pc_d, tst_d, jmp_d, ls_d, le_d;
  logic [FIELD_W-1:0] cnt_d;
  logic               done_d;

  logic [PC_W-1:0]    cand, tst_m, jmp_m, ls_m, le_m;
  logic [FIELD_W-1:0] cnt_m, trips;
  logic [PC_W-1:0]    pc_r, tst_r, jmp_r, ls_r, le_r;
  logic [FIELD_W-1:0] cnt_r;
  logic               hit;

  logic               is_flow, is_last, finish, step, is_loop;
  logic [OP_W-1:0]    op;
  logic [1:0]         len;
  logic [PC_W-1:0]    adr2, adr3;

  sfs_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  sfs_trip_calc u_trip (
    .first  (ins_w2[START_LSB +: FIELD_W]),
    .last   (ins_w2[STOP_LSB  +: FIELD_W]),
    .stride (ins_w2[INCR_LSB  +: FIELD_W]),
    .trips  (trips)
  );

  // instruction decode
  always_comb begin
    is_flow = ins_w2[FLOW_BIT];
    is_last = ins_w0[LAST_BIT];
    op      = ins_w0[OP_LSB +: OP_W];
    adr2    = ins_w2[ADR_HI:2];
    adr3    = ins_w3[ADR_HI:2];
    len     = (!is_flow && ins_has_const) ? 2'd2 : 2'd1;
    is_loop = is_flow && ((op == FC_LOOP) || (op == FC_REP));
    finish  = is_last || (is_flow && (op == FC_RET));
    step    = step_en && !done_q;
  end

  // flow-control effect, before the redirect compare
  always_comb begin
    cand  = pc_q + PC_W'(len);
    tst_m = tst_q;
    jmp_m = jmp_q;
    ls_m  = ls_q;
    le_m  = le_q;
    cnt_m = cnt_q;
    if (is_flow) begin
      case (op)
        FC_IF: begin
          if (cond_pass) begin
            if (ins_w2[30:2] < ins_w3[30:2]) begin
              tst_m = adr2;
              jmp_m = adr3;
            end
          end else begin
            cand = adr2;
          end
        end
        FC_LOOP, FC_REP: begin
          if (cond_pass) begin
            cnt_m = trips;
            ls_m  = pc_q + PC_W'(1);
            le_m  = adr3;
          end else begin
            cand = adr3;
          end
        end
        FC_BRK: begin
          if (le_q != INV) begin
            cand  = le_q;
            cnt_m = '0;
          end
        end
        default: ;
      endcase
    end
  end

  sfs_redirect #(.PC_W(PC_W)) u_redir (
    .cand  (cand),
    .tst_i (tst_m),
    .jmp_i (jmp_m),
    .ls_i  (ls_m),
    .le_i  (le_m),
    .cnt_i (cnt_m),
    .pc_o  (pc_r),
    .tst_o (tst_r),
    .jmp_o (jmp_r),
    .ls_o  (ls_r),
    .le_o  (le_r),
    .cnt_o (cnt_r),
    .hit_o (hit)
  );

  // next state
  always_comb begin
    pc_d   = pc_q;
    tst_d  = tst_q;
    jmp_d  = jmp_q;
    ls_d   = ls_q;
    le_d   = le_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (step) begin
      if (finish) begin
        done_d = 1'b1;
      end else begin
        pc_d  = pc_r;
        tst_d = tst_r;
        jmp_d = jmp_r;
        ls_d  = ls_r;
        le_d  = le_r;
        cnt_d = cnt_r;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc_q   <= '0;
      tst_q  <= INV;
      jmp_q  <= INV;
      ls_q   <= INV;
      le_q   <= INV;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      tst_q  <= tst_d;
      jmp_q  <= jmp_d;
      ls_q   <= ls_d;
      le_q   <= le_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign pc   = pc_q;
  assign done = done_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (!step_en || done_q) |=> $stable(pc_q)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    done_q |=> done_q); // R4
  AST_LAST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (step && is_last) |=> (done_q && $stable(pc_q))); // R4
  AST_RET_DONE: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (step && is_flow && (op == FC_RET)) |=> done_q); // R5
  AST_PLAIN_ADV: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (step && !is_last && !is_flow && !hit) |=> (pc_q == $past(pc_q) + PC_W'($past(len)))); // R2
  AST_LOOP_FAIL: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (step && !is_last && is_loop && !cond_pass && !hit) |=> (pc_q == $past(adr3))); // R11
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    !(step && is_loop) |=> (cnt_q <= $past(cnt_q))); // R9
endmodule

// File: tb/tb_shader_flow_seq.sv
module tb_shader_flow_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            step_en;
  logic [31:0]     ins_w0, ins_w2, ins_w3;
  logic            ins_has_const, cond_pass;
  logic [PC_W-1:0] pc;
  logic            done;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shader_flow_seq #(.PC_W(PC_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_en       (step_en),
    .ins_w0        (ins_w0),
    .ins_w2        (ins_w2),
    .ins_w3        (ins_w3),
    .ins_has_const (ins_has_const),
    .cond_pass     (cond_pass),
    .pc            (pc),
    .done          (done)
  );

  typedef struct packed {
    logic        en;
    logic        last;
    logic        flow;
    logic [5:0]  op;
    logic        cnst;
    logic        cond;
    logic [11:0] ta;
    logic [11:0] tb;
    logic [7:0]  ls;
    logic [7:0]  le;
    logic [7:0]  li;
    logic [11:0] epc;
    logic        edone;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  // en last flow op cnst cond ta tb ls le li | exp_pc exp_done | req
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,0,  0, 0,0,0,0,  1,0, 2},  // R2 plain
    '{1,0,0,0,1,0,  0, 0,0,0,0,  3,0, 2},  // R2 inline constant
    '{0,0,0,0,0,0,  0, 0,0,0,0,  3,0, 3},  // R3 no step
    '{1,0,1,3,0,1,  0, 6,5,2,1,  4,0, 9},  // R9 loop, trip 3
    '{1,0,0,0,0,0,  0, 0,0,0,0,  5,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  4,0, 9},  // R9 back to start
    '{1,0,0,0,0,0,  0, 0,0,0,0,  5,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  4,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  5,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  4,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  5,0, 9},
    '{1,0,0,0,0,0,  0, 0,0,0,0,  6,0, 9},  // R9 exit
    '{1,0,0,0,0,0,  0, 0,0,0,0,  7,0, 9},
    '{1,0,1,2,0,1,  9,12,0,0,0,  8,0, 6},  // R6 arm skip
    '{1,0,0,0,0,0,  0, 0,0,0,0, 12,0, 6},  // R6 skip taken
    '{1,0,1,2,0,0, 20, 0,0,0,0, 20,0, 8},  // R8 if fail
    '{1,0,1,2,0,1, 12,10,0,0,0, 21,0, 7},  // R7 not ordered
    '{1,0,0,0,1,0,  0, 0,0,0,0, 23,0, 2},
    '{1,0,1,2,0,1, 25,30,0,0,0, 24,0, 6},
    '{1,0,0,0,0,0,  0, 0,0,0,0, 30,0, 6},
    '{1,0,1,2,0,0, 25, 0,0,0,0, 25,0, 6},  // R6 skip disarmed
    '{1,0,1,4,0,1,  0,27,5,2,0, 26,0,10},  // R10 zero divisor
    '{1,0,0,0,0,0,  0, 0,0,0,0, 27,0,10},
    '{1,0,1,4,0,1,  0,40,3,1,1, 28,0, 9},  // R9 repeat
    '{1,0,1,0,0,0,  0, 0,0,0,0, 40,0,12},  // R12 break
    '{1,0,1,0,0,0,  0, 0,0,0,0, 41,0,12},  // R12 break, no loop
    '{1,0,1,3,0,0,  0,50,0,0,0, 50,0,11},  // R11 loop fail
    '{1,0,1,1,1,0,  0, 0,0,0,0, 51,0,13},  // R13 opcode 1, const ignored
    '{1,0,1,3,0,1,  0,53,1,4,1, 52,0,10},  // R10 negative span
    '{1,0,0,0,0,0,  0, 0,0,0,0, 53,0,10},
    '{1,0,1,3,0,1,  0,56,2,1,1, 54,0,14},
    '{1,0,1,2,0,1, 56,60,0,0,0, 55,0,14},
    '{1,0,0,0,0,0,  0, 0,0,0,0, 60,0,14},  // R14 skip beats loop end
    '{1,0,1,2,0,0, 56, 0,0,0,0, 54,0,14},  // R14 jump lands on loop end
    '{1,0,0,0,0,0,  0, 0,0,0,0, 55,0,14},
    '{1,0,0,0,0,0,  0, 0,0,0,0, 56,0,14},
    '{1,0,1,3,0,1,  0,58,5,2,2, 57,0,10},  // R10 3/2 truncates to 1
    '{1,0,0,0,0,0,  0, 0,0,0,0, 57,0,10},
    '{1,0,0,0,0,0,  0, 0,0,0,0, 58,0,10},
    '{1,0,1,5,0,0,  0, 0,0,0,0, 58,1, 5},  // R5 return
    '{1,0,0,0,1,0,  0, 0,0,0,0, 58,1, 3},  // R3 after done
    '{0,0,0,0,0,0,  0, 0,0,0,0, 58,1, 4}   // R4 done sticky
  };

  task automatic check(input string tag, input logic [PC_W-1:0] epc, input logic edone);
    checks++;
    if (pc !== epc || done !== edone) begin
      errors++;
      $display("FAIL %s: pc=%0d done=%0d expected pc=%0d done=%0d", tag, pc, done, epc, edone);
    end
  endtask

  task automatic drive(input vec_t v);
    step_en       = v.en;
    ins_has_const = v.cnst;
    cond_pass     = v.cond;
    ins_w0        = {2'b00, v.op, 23'd0, v.last};
    if (v.flow && (v.op == 6'd3 || v.op == 6'd4))
      ins_w2 = {1'b1, 4'd0, v.li, 1'b0, v.le, v.ls, 2'b00};
    else
      ins_w2 = {v.flow, 17'd0, v.ta, 2'b00};
    ins_w3 = {18'd0, v.tb, 2'b00};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0);
    do_reset();
    check("R1 reset state", '0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].epc, VEC[i].edone);
    end

    // reset in the middle of a finished program
    drive('0);
    do_reset();
    check("R1 reset clears done", '0, 1'b0);

    // R4: last marker on a two-slot instruction
    drive('{1,1,0,0,1,0, 0,0,0,0,0, 0,1, 4});
    @(negedge clk);
    check("R4 last marker", '0, 1'b1);
    drive('{1,0,0,0,0,0, 0,0,0,0,0, 0,1, 4});
    @(negedge clk);
    check("R4 hold after last", '0, 1'b1);

    // R1: fresh reset, ordinary step meets no pending address
    drive('0);
    do_reset();
    drive('{1,0,0,0,0,0, 0,0,0,0,0, 1,0, 1});
    @(negedge clk);
    check("R1 no pending after reset", 12'd1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule